// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory DMA Engine

This block moves blocks of data between two memory regions on behalf of a processor. Software programs it through a 32-bit device-control register bus. Each of four channels keeps a control word, an element count, and three 64-bit addresses: source, destination and a list pointer that is stored but not walked. The control word selects the element size (1, 2, 4 or 8 bytes). It also sets, for each side separately, whether the address steps through memory or stays fixed, and whether stepping goes up or down.

A channel starts when its control word is written with the enable bit set. One shared mover serves the enabled channels one at a time, lowest index first. For each element it issues a read and then a write on a request/grant memory port that is 64 bits wide. When the last element is written, the channel's enable bit drops and its done flag rises in a shared status word. Software clears that flag by writing a one to it.

Top module: `dma4_engine`

## Requirements
- R1: Reset sets every channel register and the status word to zero, and all of them read back as zero.
- R2: The registers of channel n sit at bus offsets 8n+0 to 8n+7. In order, these hold the control word, the count, the source high and low words, the destination high and low words, and the list-pointer high and low words. The status word is at offset 32, with the done flag of channel n in bit n. Every channel register reads back the value last written to it.
- R3: A write to a high address word changes only bits 63:32 of that address, and a write to a low word changes only bits 31:0.
- R4: Writing a control word with bit 31 set starts the channel, which copies as many elements as bits 15:0 of its count register hold. The upper count bits have no effect.
- R5: Control bits 26:25 hold a size code c, and each element is 2^c bytes. The memory port carries c on `mem_size`, and the element sits little-endian in the data lanes, with the lowest-addressed byte in bits 7:0. Bytes past the element are not written.
- R6: Control bit 23 enables source stepping and bit 24 enables destination stepping. A side with its bit clear uses the same address for every element.
- R7: When control bit 2 is set, each side whose stepping is enabled moves down by the element size after each element instead of up.
- R8: When a transfer ends, bit 31 of the channel's control word reads zero and its done flag reads one. Writing a one to a status bit clears it, and writing a zero leaves it unchanged.
- R9: A start with a count of zero completes, setting the done flag, without any memory request.
- R10: Only one channel transfers at a time. When several channels are enabled, the lowest-numbered one is served first.
- R11: Each element is one read followed by one write. A request that has not been granted stays asserted with its address and direction unchanged until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Register offset within the block |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the element |
| mem_size | output | 2 | Element size code (2^code bytes) |
| mem_wdata | output | 64 | Write data, element in the low lanes |
| mem_gnt | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 64 | Read data, little-endian from mem_addr |

## Verification
A corrupted address register or step rule shows up in memory as bytes in the wrong place, or as a fixed-address side that moves. The bench catches this with byte-exact checks that also confirm the byte just past each target region is left alone. If completion bookkeeping goes wrong, the enable bit or done flag is wrong on the first status read after the last write, which is a few cycles later. A wrong arbitration order shows while a long transfer is running: a higher-numbered channel is found done while a lower-numbered one is still waiting. A request that drops or moves before its grant is flagged on the very next clock edge.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int WORD_W  = 32;
    localparam int MADDR_W = 64;
    localparam int MDATA_W = 64;
    localparam int CNT_W   = 16;

    // control word field positions
    localparam int CTL_EN   = 31;
    localparam int CTL_SZHI = 26;
    localparam int CTL_SZLO = 25;
    localparam int CTL_DINC = 24;
    localparam int CTL_SINC = 23;
    localparam int CTL_DOWN = 2;

    typedef enum logic [2:0] {
        SL_CTRL   = 3'd0,
        SL_COUNT  = 3'd1,
        SL_SRC_HI = 3'd2,
        SL_SRC_LO = 3'd3,
        SL_DST_HI = 3'd4,
        SL_DST_LO = 3'd5,
        SL_LST_HI = 3'd6,
        SL_LST_LO = 3'd7
    } slot_e;

    typedef struct packed {
        logic [WORD_W-1:0]  ctrl;
        logic [WORD_W-1:0]  count;
        logic [MADDR_W-1:0] src;
        logic [MADDR_W-1:0] dst;
        logic [MADDR_W-1:0] lst;
    } chan_regs_t;

    typedef enum logic [1:0] {
        MV_IDLE   = 2'd0,
        MV_READ   = 2'd1,
        MV_WRITE  = 2'd2,
        MV_FINISH = 2'd3
    } mv_state_e;
endpackage

// File: rtl/dma4_chan_regs.sv
module dma4_chan_regs
    import dma4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_en,
    output chan_regs_t        regs
);
    chan_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (slot_e'(wr_slot))
                SL_CTRL:   r_d.ctrl         = wr_data;
                SL_COUNT:  r_d.count        = wr_data;
                SL_SRC_HI: r_d.src[63:32]   = wr_data;
                SL_SRC_LO: r_d.src[31:0]    = wr_data;
                SL_DST_HI: r_d.dst[63:32]   = wr_data;
                SL_DST_LO: r_d.dst[31:0]    = wr_data;
                SL_LST_HI: r_d.lst[63:32]   = wr_data;
                SL_LST_LO: r_d.lst[31:0]    = wr_data;
                default:   r_d              = r_q;
            endcase
        end
        // completion wins over a same-cycle bus write
        if (clr_en) r_d.ctrl[CTL_EN] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs = r_q;

    assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == 3'(SL_SRC_HI)) |=> (regs.src[31:0] == $past(regs.src[31:0])));

    assert_lo_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot == 3'(SL_DST_LO)) |=> (regs.dst[63:32] == $past(regs.dst[63:32])));
endmodule

// File: rtl/dma4_prio_arb.sv
module dma4_prio_arb #(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_CH-1:0] req,
    output logic              gnt_vld,
    output logic [IDX_W-1:0]  gnt_idx
);
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_vld = 1'b1;
                gnt_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
    import dma4_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld,
    input  logic [IDX_W-1:0]   req_ch,
    input  logic [WORD_W-1:0]  cfg_ctrl,
    input  logic [CNT_W-1:0]   cfg_cnt,
    input  logic [MADDR_W-1:0] cfg_src,
    input  logic [MADDR_W-1:0] cfg_dst,
    output logic               busy,
    output logic               fin,
    output logic [IDX_W-1:0]   fin_ch,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [1:0]         mem_size,
    output logic [MDATA_W-1:0] mem_wdata,
    input  logic               mem_gnt,
    input  logic [MDATA_W-1:0] mem_rdata
);
    typedef struct packed {
        mv_state_e          st;
        logic [IDX_W-1:0]   ch;
        logic [MADDR_W-1:0] src;
        logic [MADDR_W-1:0] dst;
        logic [CNT_W-1:0]   rem;
        logic [1:0]         code;
        logic               sinc;
        logic               dinc;
        logic               down;
        logic [MDATA_W-1:0] data;
    } mv_t;

    mv_t s_d, s_q;

    function automatic logic [MADDR_W-1:0] next_addr(
        input logic [MADDR_W-1:0] a, input logic [1:0] code,
        input logic step, input logic down);
        logic [MADDR_W-1:0] amt;
        amt = MADDR_W'(1) << code;
        if (!step)     return a;
        else if (down) return a - amt;
        else           return a + amt;
    endfunction

    function automatic logic [MDATA_W-1:0] lane_mask(input logic [1:0] code);
        if (code == 2'd3) return '1;
        else              return (MDATA_W'(1) << (8 << code)) - MDATA_W'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            MV_IDLE: begin
                if (req_vld) begin
                    s_d.ch   = req_ch;
                    s_d.src  = cfg_src;
                    s_d.dst  = cfg_dst;
                    s_d.rem  = cfg_cnt;
                    s_d.code = cfg_ctrl[CTL_SZHI:CTL_SZLO];
                    s_d.sinc = cfg_ctrl[CTL_SINC];
                    s_d.dinc = cfg_ctrl[CTL_DINC];
                    s_d.down = cfg_ctrl[CTL_DOWN];
                    s_d.st   = (cfg_cnt == '0) ? MV_FINISH : MV_READ;
                end
            end
            MV_READ: begin
                if (mem_gnt) begin
                    s_d.data = mem_rdata & lane_mask(s_q.code);
                    s_d.st   = MV_WRITE;
                end
            end
            MV_WRITE: begin
                if (mem_gnt) begin
                    s_d.src = next_addr(s_q.src, s_q.code, s_q.sinc, s_q.down);
                    s_d.dst = next_addr(s_q.dst, s_q.code, s_q.dinc, s_q.down);
                    s_d.rem = s_q.rem - CNT_W'(1);
                    s_d.st  = (s_q.rem == CNT_W'(1)) ? MV_FINISH : MV_READ;
                end
            end
            default: s_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != MV_IDLE);
    assign fin       = (s_q.st == MV_FINISH);
    assign fin_ch    = s_q.ch;
    assign mem_req   = (s_q.st == MV_READ) || (s_q.st == MV_WRITE);
    assign mem_we    = (s_q.st == MV_WRITE);
    assign mem_addr  = (s_q.st == MV_WRITE) ? s_q.dst : s_q.src;
    assign mem_size  = s_q.code;
    assign mem_wdata = s_q.data;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_read_then_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_gnt) |=> (mem_req && mem_we));

    assert_narrow_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_size != 2'd3) |-> ((mem_wdata >> (8 << mem_size)) == '0));

    assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !busy && cfg_cnt == '0) |=> (fin && !mem_req));
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RA_W   = $clog2(NUM_CH * 8) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [RA_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [1:0]         mem_size,
    output logic [MDATA_W-1:0] mem_wdata,
    input  logic               mem_gnt,
    input  logic [MDATA_W-1:0] mem_rdata
);
    localparam logic [RA_W-1:0] STAT_OFS = RA_W'(NUM_CH * 8);

    chan_regs_t         regs_arr [NUM_CH];
    logic [NUM_CH-1:0]  en_vec;
    logic [NUM_CH-1:0]  stat_d, stat_q;
    logic               chan_hit;
    logic [IDX_W-1:0]   acc_ch;
    logic [2:0]         acc_slot;
    logic               arb_vld, mv_busy, mv_fin;
    logic [IDX_W-1:0]   arb_idx, mv_fin_ch;

    assign chan_hit = (reg_addr < STAT_OFS);
    assign acc_ch   = reg_addr[IDX_W+2:3];
    assign acc_slot = reg_addr[2:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic wr_here;
        assign wr_here = reg_sel && reg_wr && chan_hit && (acc_ch == IDX_W'(i));
        dma4_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_here),
            .wr_slot (acc_slot),
            .wr_data (reg_wdata),
            .clr_en  (mv_fin && (mv_fin_ch == IDX_W'(i))),
            .regs    (regs_arr[i])
        );
        assign en_vec[i] = regs_arr[i].ctrl[CTL_EN];
    end

    dma4_prio_arb #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_arb (
        .req     (en_vec),
        .gnt_vld (arb_vld),
        .gnt_idx (arb_idx)
    );

    dma4_mover #(.IDX_W(IDX_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (arb_vld),
        .req_ch    (arb_idx),
        .cfg_ctrl  (regs_arr[arb_idx].ctrl),
        .cfg_cnt   (regs_arr[arb_idx].count[CNT_W-1:0]),
        .cfg_src   (regs_arr[arb_idx].src),
        .cfg_dst   (regs_arr[arb_idx].dst),
        .busy      (mv_busy),
        .fin       (mv_fin),
        .fin_ch    (mv_fin_ch),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata)
    );

    // done flags: write-one-to-clear, completion sets and wins
    always_comb begin
        stat_d = stat_q;
        if (reg_sel && reg_wr && reg_addr == STAT_OFS)
            stat_d = stat_q & ~reg_wdata[NUM_CH-1:0];
        if (mv_fin)
            stat_d[mv_fin_ch] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (chan_hit) begin
            case (slot_e'(acc_slot))
                SL_CTRL:   reg_rdata = regs_arr[acc_ch].ctrl;
                SL_COUNT:  reg_rdata = regs_arr[acc_ch].count;
                SL_SRC_HI: reg_rdata = regs_arr[acc_ch].src[63:32];
                SL_SRC_LO: reg_rdata = regs_arr[acc_ch].src[31:0];
                SL_DST_HI: reg_rdata = regs_arr[acc_ch].dst[63:32];
                SL_DST_LO: reg_rdata = regs_arr[acc_ch].dst[31:0];
                SL_LST_HI: reg_rdata = regs_arr[acc_ch].lst[63:32];
                SL_LST_LO: reg_rdata = regs_arr[acc_ch].lst[31:0];
                default:   reg_rdata = '0;
            endcase
        end else if (reg_addr == STAT_OFS) begin
            reg_rdata = WORD_W'(stat_q);
        end
    end

    assert_fin_clears_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mv_fin |=> (!en_vec[$past(mv_fin_ch)] && stat_q[$past(mv_fin_ch)]));

    assert_no_mem_while_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_busy |-> !mem_req);
endmodule

// File: tb/dma4_engine_bench.sv
module dma4_engine_bench;
    localparam int STAT = 32;
    localparam logic [31:0] EN = 32'h8000_0000, DINC = 32'h0100_0000,
                            SINC = 32'h0080_0000, DOWN = 32'h0000_0004;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    logic [7:0]  m [256];
    logic        gnt_phase = 1'b0;
    int          total = 0, bad = 0, viol = 0, nrd = 0, nwr = 0;
    logic        prev_wait = 1'b0, prev_we = 1'b0;
    logic [63:0] prev_addr = '0;
    bit          finished = 0;

    always #10 clk = ~clk;

    dma4_engine u_dma4_engine (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata));

    // memory model: grants every other cycle, little-endian byte lanes
    assign mem_gnt = mem_req && gnt_phase;
    always @(posedge clk) gnt_phase <= ~gnt_phase;

    always_comb begin
        for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = m[8'(mem_addr[7:0] + 8'(k))];
    end

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_gnt)
            for (int k = 0; k < (1 << mem_size); k++)
                m[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[8*k +: 8];
    end

    // R11 protocol monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_wait && (!mem_req || mem_addr != prev_addr || mem_we != prev_we)) viol++;
            if (mem_req && mem_gnt) begin
                if (mem_we) nwr++; else nrd++;
            end
        end
        prev_wait <= rst_n && mem_req && !mem_gnt;
        prev_addr <= mem_addr;
        prev_we   <= mem_we;
    end

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) m[i] = pat(i);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 6'(a);
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic launch(input int ch, input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] cnt, input logic [31:0] ctl);
        wr(ch*8+1, cnt);
        wr(ch*8+2, 32'h0); wr(ch*8+3, src);
        wr(ch*8+4, 32'h0); wr(ch*8+5, dst);
        wr(ch*8+0, ctl);
    endtask

    task automatic wait_done(input int ch);
        logic [31:0] s;
        for (int n = 0; n < 3000; n++) begin
            rd(STAT, s);
            if (s[ch]) return;
        end
        chk("R8 done timeout", 0, 1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a <= STAT; a++) begin
            rd(a, v);
            chk($sformatf("R1 reset reg %0d", a), v, 0);
        end
    endtask

    task automatic t_map();
        logic [31:0] v;
        logic [31:0] vals [8] = '{32'h0000_1234, 32'hBEEF_0005, 32'h1111_1111, 32'h2222_2222,
                                  32'h3333_3333, 32'h4444_4444, 32'h5555_5555, 32'h6666_6666};
        int r0 = nrd;
        for (int s = 0; s < 8; s++) wr(8 + s, vals[s]);
        for (int s = 0; s < 8; s++) begin
            rd(8 + s, v);
            chk($sformatf("R2 map slot %0d", s), v, vals[s]);
        end
        wr(8 + 2, 32'h7777_7777);
        rd(8 + 3, v); chk("R3 low kept", v, 32'h2222_2222);
        rd(8 + 2, v); chk("R3 high new", v, 32'h7777_7777);
        wr(8 + 5, 32'h9999_9999);
        rd(8 + 4, v); chk("R3 high kept", v, 32'h3333_3333);
        chk("R4 no start without enable", nrd - r0, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < 8; s++) begin
            rd(8 + s, v);
            chk("R1 cleared by reset", v, 0);
        end
    endtask

    task automatic t_copy();
        logic [31:0] v;
        init_mem();
        launch(0, 32'h10, 32'h80, 32'h0007_0003, EN | (2 << 25) | DINC | SINC);
        wait_done(0);
        for (int k = 0; k < 12; k++) chk("R4 copy byte", m[8'h80 + k], pat(8'h10 + k));
        chk("R4 count upper bits ignored", m[8'h8C], pat(8'h8C));
        rd(0, v); chk("R8 enable cleared", v, (2 << 25) | DINC | SINC);
        rd(STAT, v); chk("R8 done flag", v, 32'h1);
        wr(STAT, 32'h0); rd(STAT, v); chk("R8 write zero keeps", v, 32'h1);
        wr(STAT, 32'h1); rd(STAT, v); chk("R8 write one clears", v, 32'h0);
    endtask

    task automatic t_width();
        init_mem();
        launch(1, 32'h30, 32'h90, 32'd3, EN | DINC | SINC);
        wait_done(1); wr(STAT, 32'hF);
        for (int k = 0; k < 3; k++) chk("R5 byte elems", m[8'h90 + k], pat(8'h30 + k));
        chk("R5 byte tail", m[8'h93], pat(8'h93));
        init_mem();
        launch(1, 32'h00, 32'hC0, 32'd2, EN | (3 << 25) | DINC | SINC);
        wait_done(1); wr(STAT, 32'hF);
        for (int k = 0; k < 16; k++) chk("R5 dword elems", m[8'hC0 + k], pat(k));
        chk("R5 dword tail", m[8'hD0], pat(8'hD0));
    endtask

    task automatic t_fixed();
        init_mem();
        launch(2, 32'h20, 32'h60, 32'd4, EN | DINC);
        wait_done(2); wr(STAT, 32'hF);
        for (int k = 0; k < 4; k++) chk("R6 fixed source", m[8'h60 + k], pat(8'h20));
        chk("R6 fixed source tail", m[8'h64], pat(8'h64));
        init_mem();
        launch(2, 32'h40, 32'h70, 32'd3, EN | (1 << 25) | SINC);
        wait_done(2); wr(STAT, 32'hF);
        chk("R6 fixed dest lo", m[8'h70], pat(8'h44));
        chk("R6 fixed dest hi", m[8'h71], pat(8'h45));
        chk("R6 fixed dest tail", m[8'h72], pat(8'h72));
    endtask

    task automatic t_down();
        init_mem();
        launch(3, 32'h48, 32'hA8, 32'd3, EN | (1 << 25) | DINC | SINC | DOWN);
        wait_done(3); wr(STAT, 32'hF);
        for (int k = 0; k < 6; k++) chk("R7 down copy", m[8'hA4 + k], pat(8'h44 + k));
        chk("R7 below untouched", m[8'hA3], pat(8'hA3));
        chk("R7 above untouched", m[8'hAA], pat(8'hAA));
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int r0 = nrd, w0 = nwr;
        launch(2, 32'h00, 32'h80, 32'h0001_0000, EN | DINC | SINC);
        wait_done(2);
        chk("R9 no reads", nrd - r0, 0);
        chk("R9 no writes", nwr - w0, 0);
        rd(16, v); chk("R9 enable cleared", v[31], 0);
        wr(STAT, 32'hF);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        init_mem();
        launch(3, 32'h00, 32'h80, 32'd40, EN | DINC | SINC);
        launch(2, 32'h00, 32'hC0, 32'd2, EN | DINC | SINC);
        launch(1, 32'h00, 32'hE0, 32'd2, EN | DINC | SINC);
        wait_done(1);
        rd(STAT, v);
        chk("R10 ch3 before", v[3], 1);
        chk("R10 ch2 still waits", v[2], 0);
        wait_done(2);
        chk("R10 ch1 data", m[8'hE1], pat(1));
        chk("R10 ch2 data", m[8'hC1], pat(1));
        chk("R10 ch3 data", m[8'h80 + 39], pat(39));
        wr(STAT, 32'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_copy();
        t_width();
        t_fixed();
        t_down();
        t_zero();
        t_prio();
        repeat (4) @(negedge clk);
        chk("R11 request held until grant", viol, 0);
        chk("R11 one read per write", nrd, nwr);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule